// File: doc/BRIEF.md
# Mailbox Command Handshake Controller

This block lets on-chip host logic hand a command to a power-management microcontroller through three memory-mapped registers and collect the outcome. A start pulse captures a message identifier, an optional 32-bit parameter and a flag that marks the command as a query. The controller then uses a simple request/acknowledge register-bus master to write the parameter to the argument register, if there is one, and then the trimmed identifier to the message register.

After the message is written, the controller reads the response register once per microsecond tick. The tick comes from a prescaler on the system clock. A zero response means the command is still pending. Polling stops when a nonzero response arrives or when the poll budget runs out. One last read of the response register then gives the result code. Two reserved codes count as failures. Every other code counts as completion, and so does a silent timeout, which is flagged only on a separate status output. A query that does not fail also reads the argument register back as its result word.

Top module: `mbox_handshake`

## Requirements
- R1: When the parameter-valid input is high at start, the argument register (address ARG_ADDR) is written with the parameter before the message register (MSG_ADDR) is written. When it is low, no write to the argument register happens. Exactly one message write is made per command.
- R2: The message write data equals the identifier with every bit at and above position MSG_W forced to zero.
- R3: The response register (RESP_ADDR) is read at most once per tick while its low RESP_W bits read zero. Successive pending polls are exactly DIV clock cycles apart when the bus answers within DIV-2 cycles.
- R4: Polling ends either at the first nonzero response or after TMO_N zero polls. Exactly one further read of the response register follows, so a command that never gets an answer makes TMO_N+1 response reads.
- R5: When the low RESP_W bits of the final response read are 8'hFF or 8'hFE, the error output is high with done.
- R6: Any other nonzero final code (for example 1, 2, 8'h7F) completes with both the error and timeout outputs low. Bits of the response word above RESP_W are ignored.
- R7: When the final code is zero (timeout), the timeout output is high and the error output is low with done.
- R8: For a query that did not fail, the argument register is read once after the final response read, and the result output equals that read data. In every other case there is no argument read, and the result equals the final code zero-extended to 32 bits.
- R9: Busy is high in the cycle after an accepted start. A start while busy is ignored. Done is a single-cycle pulse, in the same cycle that busy falls.
- R10: After reset, busy, done, error, timeout, bus request and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| msg_id_i | input | ID_W | Message identifier |
| has_arg_i | input | 1 | Parameter valid; write it to the argument register first |
| arg_i | input | 32 | Command parameter |
| query_i | input | 1 | Read the argument register back as the result |
| busy_o | output | 1 | A command is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure code received (held until the next start) |
| tmo_o | output | 1 | Poll budget expired with no response (held) |
| result_o | output | 32 | Result word (held) |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with the acknowledge |
| bus_ack_i | input | 1 | Single-cycle transfer acknowledge |

## Verification
Busy is due one edge after the start edge. The done, error, timeout and result outputs are all due one edge after the acknowledge of the last bus read: the final response read, or the argument read-back for a query. The bench therefore waits for done at falling edges and samples every completion output in that same half-cycle, then checks that done and busy are both low one cycle later. Bus ordering, write data and the spacing of response reads are logged by the responder model at the edge where it acknowledges each transfer. With a one-cycle acknowledge and DIV of 4, consecutive pending polls are expected exactly 4 cycles apart.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WARG  = 3'd1,
      ST_WMSG  = 3'd2,
      ST_WAIT  = 3'd3,
      ST_POLL  = 3'd4,
      ST_FINAL = 3'd5,
      ST_RARG  = 3'd6
   } mbox_state_t;

endpackage

// File: rtl/mbox_usec_tick.sv
module mbox_usec_tick #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [TW-1:0] LAST = TW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("mbox_usec_tick: DIV must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= (cnt_q == LAST);
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: a tick never lasts two cycles
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/mbox_resp_class.sv
module mbox_resp_class #(
   parameter int              RESP_W = 8,
   parameter logic [7:0]      FAIL_A = 8'hFF,
   parameter logic [7:0]      FAIL_B = 8'hFE
) (
   input  logic [RESP_W-1:0] code_i,
   output logic              pending_o,
   output logic              fail_o
);
   generate
      if (RESP_W < 8) begin : g_bad_w
         $error("mbox_resp_class: RESP_W must be at least 8");
      end
   endgenerate

   localparam logic [RESP_W-1:0] FA = RESP_W'(FAIL_A);
   localparam logic [RESP_W-1:0] FB = RESP_W'(FAIL_B);

   always_comb begin
      pending_o = (code_i == '0);
      fail_o    = (code_i == FA) || (code_i == FB);
   end

endmodule

// File: rtl/mbox_handshake.sv
module mbox_handshake
   import mbox_pkg::*;
#(
   parameter int          ID_W      = 16,
   parameter int          MSG_W     = 10,
   parameter int          RESP_W    = 8,
   parameter int          ADDR_W    = 8,
   parameter int          DIV       = 100,
   parameter int          TMO_N     = 100000,
   parameter logic [7:0]  MSG_ADDR  = 8'h10,
   parameter logic [7:0]  ARG_ADDR  = 8'h14,
   parameter logic [7:0]  RESP_ADDR = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ID_W-1:0]   msg_id_i,
   input  logic              has_arg_i,
   input  logic [31:0]       arg_i,
   input  logic              query_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              tmo_o,
   output logic [31:0]       result_o,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [31:0]       bus_wdata_o,
   input  logic [31:0]       bus_rdata_i,
   input  logic              bus_ack_i
);
   localparam int PC_W = $clog2(TMO_N + 1);
   localparam logic [PC_W-1:0] PC_LIM = PC_W'(TMO_N);
   localparam logic [ID_W-1:0] ID_MASK = ID_W'((64'd1 << MSG_W) - 64'd1);
   localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(MSG_ADDR);
   localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(ARG_ADDR);
   localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(RESP_ADDR);

   generate
      if (MSG_W >= ID_W || ID_W > 32) begin : g_bad_id
         $error("mbox_handshake: need MSG_W < ID_W <= 32");
      end
      if (RESP_W > 32 || TMO_N < 1) begin : g_bad_resp
         $error("mbox_handshake: need RESP_W <= 32 and TMO_N >= 1");
      end
   endgenerate

   mbox_state_t      state_q;
   logic [ID_W-1:0]  id_q;
   logic [31:0]      arg_q;
   logic             query_q;
   logic [PC_W-1:0]  poll_q;
   logic             tick;
   logic             code_pending;
   logic             code_fail;
   logic [RESP_W-1:0] code_w;

   assign code_w = bus_rdata_i[RESP_W-1:0];

   mbox_usec_tick #(.DIV(DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   mbox_resp_class #(.RESP_W(RESP_W)) u_class (
      .code_i    (code_w),
      .pending_o (code_pending),
      .fail_o    (code_fail)
   );

   // bus drive decoded from state
   always_comb begin
      bus_req_o   = 1'b0;
      bus_we_o    = 1'b0;
      bus_addr_o  = A_RESP;
      bus_wdata_o = '0;
      unique case (state_q)
         ST_WARG: begin
            bus_req_o = 1'b1; bus_we_o = 1'b1;
            bus_addr_o = A_ARG; bus_wdata_o = arg_q;
         end
         ST_WMSG: begin
            bus_req_o = 1'b1; bus_we_o = 1'b1;
            bus_addr_o = A_MSG; bus_wdata_o = 32'(id_q);
         end
         ST_POLL, ST_FINAL: begin
            bus_req_o = 1'b1; bus_addr_o = A_RESP;
         end
         ST_RARG: begin
            bus_req_o = 1'b1; bus_addr_o = A_ARG;
         end
         default: ;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         id_q     <= '0;
         arg_q    <= '0;
         query_q  <= 1'b0;
         poll_q   <= '0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
         tmo_o    <= 1'b0;
         result_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               id_q    <= msg_id_i & ID_MASK;
               arg_q   <= arg_i;
               query_q <= query_i;
               err_o   <= 1'b0;
               tmo_o   <= 1'b0;
               state_q <= has_arg_i ? ST_WARG : ST_WMSG;
            end
            ST_WARG: if (bus_ack_i) state_q <= ST_WMSG;
            ST_WMSG: if (bus_ack_i) begin
               poll_q  <= '0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: if (tick) state_q <= ST_POLL;
            ST_POLL: if (bus_ack_i) begin
               if (!code_pending) begin
                  state_q <= ST_FINAL;
               end else begin
                  poll_q  <= poll_q + 1'b1;
                  state_q <= (poll_q + 1'b1 == PC_LIM) ? ST_FINAL : ST_WAIT;
               end
            end
            ST_FINAL: if (bus_ack_i) begin
               err_o <= code_fail;
               tmo_o <= code_pending;
               if (query_q && !code_fail) begin
                  state_q <= ST_RARG;
               end else begin
                  result_o <= 32'(code_w);
                  done_o   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_RARG: if (bus_ack_i) begin
               result_o <= bus_rdata_i;
               done_o   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: a pending transfer keeps its address and data until acknowledged
   a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
                                     && $stable(bus_we_o) && $stable(bus_wdata_o)));
   // R9: done is a single-cycle pulse and coincides with idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R9: an idle start makes the block busy on the next cycle
   a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   // R7: error and timeout never report together
   a_r7_err_tmo_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(err_o && tmo_o));
   // R4: the poll counter never passes its budget
   a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q <= PC_LIM);

endmodule

// File: tb/sim_mbox_handshake.sv
module sim_mbox_handshake;
   localparam int ID_W = 16, MSG_W = 10, RESP_W = 8, ADDR_W = 8;
   localparam int DIV = 4, TMO_N = 5;
   localparam logic [7:0] A_MSG = 8'h10, A_ARG = 8'h14, A_RESP = 8'h18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              start_i = 1'b0;
   logic [ID_W-1:0]   msg_id_i = '0;
   logic              has_arg_i = 1'b0;
   logic [31:0]       arg_i = '0;
   logic              query_i = 1'b0;
   logic              busy_o, done_o, err_o, tmo_o;
   logic [31:0]       result_o;
   logic              bus_req_o, bus_we_o;
   logic [ADDR_W-1:0] bus_addr_o;
   logic [31:0]       bus_wdata_o;
   logic [31:0]       bus_rdata_i;
   logic              bus_ack_i;

   mbox_handshake #(
      .ID_W(ID_W), .MSG_W(MSG_W), .RESP_W(RESP_W), .ADDR_W(ADDR_W),
      .DIV(DIV), .TMO_N(TMO_N),
      .MSG_ADDR(A_MSG), .ARG_ADDR(A_ARG), .RESP_ADDR(A_RESP)
   ) u0 (.*);

   // ---------------- responder model ----------------
   logic [7:0]  fw_code = 8'h00;
   int          fw_delay = 0;
   logic [7:0]  fw_resp;
   logic [31:0] fw_arg;
   logic        fw_armed;
   int          fw_cnt;
   int          cyc;
   int          n_argw, n_msgw, n_respr, n_argr, order_bad, argr_early;
   logic [31:0] last_msg, last_argw;
   int          stamp [0:15];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack_i <= 1'b0; bus_rdata_i <= '0;
         fw_resp <= 8'h00; fw_arg <= 32'h1234_0000;
         fw_armed <= 1'b0; fw_cnt <= 0; cyc <= 0;
      end else begin
         cyc <= cyc + 1;
         bus_ack_i <= 1'b0;
         if (fw_armed) begin
            if (fw_cnt == 0) begin fw_resp <= fw_code; fw_armed <= 1'b0; end
            else fw_cnt <= fw_cnt - 1;
         end
         if (bus_req_o && !bus_ack_i) begin
            bus_ack_i <= 1'b1;
            if (bus_we_o) begin
               if (bus_addr_o == A_ARG) begin
                  fw_arg <= bus_wdata_o; last_argw <= bus_wdata_o;
                  n_argw <= n_argw + 1;
                  if (n_msgw != 0) order_bad <= order_bad + 1;
               end else if (bus_addr_o == A_MSG) begin
                  last_msg <= bus_wdata_o; n_msgw <= n_msgw + 1;
                  fw_arg <= fw_arg ^ 32'h5A00_0000 ^ bus_wdata_o;
                  fw_resp <= 8'h00;
                  fw_armed <= (fw_code != 8'h00);
                  fw_cnt <= fw_delay;
               end
            end else begin
               if (bus_addr_o == A_RESP) begin
                  bus_rdata_i <= {24'hC3A5E1, fw_resp};
                  if (n_respr < 16) stamp[n_respr] <= cyc;
                  n_respr <= n_respr + 1;
                  if (n_argr != 0) argr_early <= argr_early + 1;
               end else begin
                  bus_rdata_i <= fw_arg;
                  n_argr <= n_argr + 1;
               end
            end
         end
      end
   end

   // ---------------- scoring ----------------
   int n_chk = 0, n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [15:0] id, input logic ha, input logic [31:0] arg,
                          input logic q, input logic [7:0] code, input int dly);
      logic [31:0] exp_arg, exp_res;
      logic        exp_err, exp_tmo;
      int          w;
      fw_code = code; fw_delay = dly;
      n_argw = 0; n_msgw = 0; n_respr = 0; n_argr = 0; order_bad = 0; argr_early = 0;
      exp_arg = (ha ? arg : fw_arg) ^ 32'h5A00_0000 ^ 32'(id & 16'h03FF);
      exp_err = (code == 8'hFF) || (code == 8'hFE);
      exp_tmo = (code == 8'h00);
      exp_res = (q && !exp_err) ? exp_arg : {24'h0, code};
      @(negedge clk);
      msg_id_i = id; has_arg_i = ha; arg_i = arg; query_i = q; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 busy after start", 32'(busy_o), 32'd1);
      @(negedge clk);
      msg_id_i = ~id; has_arg_i = 1'b1; arg_i = ~arg; start_i = 1'b1;   // must be ignored
      @(negedge clk);
      start_i = 1'b0;
      w = 0;
      while (!done_o && w < 1000) begin @(negedge clk); w++; end
      if (w >= 1000) chk("R9 watchdog done", 32'd0, 32'd1);
      chk("R5 err", 32'(err_o), 32'(exp_err));
      chk("R7 tmo", 32'(tmo_o), 32'(exp_tmo));
      if (!exp_err && !exp_tmo) chk("R6 clean completion", {30'd0, err_o, tmo_o}, 32'd0);
      chk("R8 result", result_o, exp_res);
      chk("R1 msg writes", 32'(n_msgw), 32'd1);
      chk("R1 arg writes", 32'(n_argw), ha ? 32'd1 : 32'd0);
      chk("R1 order", 32'(order_bad), 32'd0);
      if (ha) chk("R1 arg data", last_argw, arg);
      chk("R2 masked id", last_msg, 32'(id & 16'h03FF));
      chk("R8 arg reads", 32'(n_argr), (q && !exp_err) ? 32'd1 : 32'd0);
      chk("R8 arg read last", 32'(argr_early), 32'd0);
      if (exp_tmo) begin
         chk("R4 resp reads on timeout", 32'(n_respr), 32'(TMO_N + 1));
         for (int i = 0; i < TMO_N - 1; i++)
            chk("R3 poll spacing", 32'(stamp[i+1] - stamp[i]), 32'(DIV));
      end else begin
         chk("R4 final read follows", 32'(n_respr >= 2), 32'd1);
      end
      @(negedge clk);
      chk("R9 done one cycle", {30'd0, done_o, busy_o}, 32'd0);
   endtask

   initial begin
      logic [7:0] codes [0:5];
      codes[0] = 8'h01; codes[1] = 8'h02; codes[2] = 8'h7F;
      codes[3] = 8'hFE; codes[4] = 8'hFF; codes[5] = 8'h00;
      #1;
      chk("R10 reset busy/done", {30'd0, busy_o, done_o}, 32'd0);
      chk("R10 reset err/tmo/req", {29'd0, err_o, tmo_o, bus_req_o}, 32'd0);
      chk("R10 reset result", result_o, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 6; c++)
         for (int h = 0; h < 2; h++)
            for (int q = 0; q < 2; q++) begin
               int k;
               k = c * 4 + h * 2 + q;
               run_cmd(16'hF000 | 16'(k * 37 + 5), h[0], 32'hA000_0000 + 32'(k * 333),
                       q[0], codes[c], k % 3 + (c == 2 ? 7 : 0));
            end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule